// File: doc/BRIEF.md
# Interleaved Multi-Width Multiply Sequencer

This block drives one deeply pipelined N×N word multiplier through the three multiplication steps of a modular reduction for primes shaped like a power-of-two times a constant, minus one. The first step forms the full product of two 2N-bit operands. The upper part of that product, above a fixed split point, is multiplied by a 2N-bit Barrett constant. A slice of that result, the approximate quotient, is then multiplied by an N-bit constant. Each step is broken into word-pair issues: 4 for the first step, 6 for the second and 2 for the third. Each returning word product is shifted and added into a result register that belongs to its own operand set.

Two operand sets are loaded by one start pulse and run interleaved. A step of one set may begin only after every product of that set's previous step has returned. The sequencer fills that gap with issues from the other set. Issues go out in bursts: once a set begins a step, all of that step's word pairs go out back to back. A done strobe marks the end of each set, and the set's split results are presented on the output ports during that cycle. Post-processing of these results happens elsewhere.

Top module: `dual_set_mul_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `busy` and `done` are both 0.
- R2: `start` is accepted only while `busy` is 0. A `start` pulse raised while `busy` is 1 has no effect: the operands and constants it presents are not used, and the batch already running produces its original results with its original timing.
- R3: If `start` is accepted in cycle s, then `busy` is 1 from cycle s+1 through cycle s+45 and is 0 in cycle s+46.
- R4: The multiplier accepts at most one word pair per cycle and returns each product 9 cycles after issue. Set 0 issues first. A set that has begun a step finishes that step's issues before the other set issues. Otherwise the set not served last goes next, if it is ready. With this policy, `done` is 1 in cycle s+40 with `done_set` equal to 0 (set 0).
- R5: `done` is 1 in cycle s+46 with `done_set` equal to 1 (set 1). In every other cycle of the batch `done` is 0, so each strobe lasts exactly one cycle.
- R6: In a done cycle, `res_rem` equals the low ALPHA bits of A×B for the finished set.
- R7: In a done cycle, `res_quo` equals A×B shifted right by ALPHA bits, 3N bits wide.
- R8: In a done cycle, `res_bq` equals bits KSH through KSH+2N-1 of `res_quo` times the Barrett constant.
- R9: In a done cycle, `res_bqm` equals `res_bq` times the N-bit constant, 3N bits wide.
- R10: A start presented in the cycle of the set 1 done strobe is accepted. The new batch follows the same timing as R3 to R5, so two results are produced every 46 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a batch of two operand sets |
| busy | output | 1 | A batch is in progress |
| op_a0 | input | 2N | First operand, set 0 |
| op_b0 | input | 2N | Second operand, set 0 |
| op_a1 | input | 2N | First operand, set 1 |
| op_b1 | input | 2N | Second operand, set 1 |
| barrett_x | input | 2N | Barrett constant used in the second step |
| mod_m | input | N | Constant used in the third step |
| done | output | 1 | One-cycle strobe: a set has finished |
| done_set | output | 1 | Index of the set that finished |
| res_rem | output | ALPHA | Low split of the first product |
| res_quo | output | 3N | High split of the first product |
| res_bq | output | 2N | Approximate quotient |
| res_bqm | output | 3N | Approximate quotient times the N-bit constant |

## Verification
The bench sweeps operand patterns that force carries across every word boundary: all zeros, all ones, single low bits and pseudo-random values. It checks that each returning partial product lands at the correct shift and in the correct set. A design that mixed up the set tags or the word offsets would give wrong quotients even though its timing was right. The bench also counts cycles exactly, from start to each done strobe and to the fall of `busy`. A scheduler that began a step before the previous one had drained would produce wrong values. One that served the sets in the wrong order would move the strobes off cycles s+40 and s+46. Back-to-back batches, and start pulses raised mid-batch with different operands, expose a sequencer that fails to capture its operands or that restarts while busy.

// File: rtl/dsms_pkg.sv
// Shared types for the interleaved multiply sequencer.
// Assumes exactly two operand sets and three multiply steps.
package dsms_pkg;

    localparam int NUM_SETS = 2;

    typedef enum logic [1:0] {
        PH_PROD    = 2'd0,
        PH_BARRETT = 2'd1,
        PH_FOLD    = 2'd2,
        PH_DONE    = 2'd3
    } phase_e;

    typedef struct packed {
        logic       set;
        phase_e     phase;
        logic [1:0] wi;
        logic       wj;
    } tag_t;

    // Number of word-pair issues each step needs
    function automatic logic [2:0] words_in_phase(phase_e ph);
        case (ph)
            PH_PROD:    return 3'd4;
            PH_BARRETT: return 3'd6;
            PH_FOLD:    return 3'd2;
            default:    return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/dsms_mul_pipe.sv
// Pipelined W x W multiplier model with a tag carried alongside.
// The product is formed at the input stage and delayed through LAT
// register stages. An issue in cycle t is visible at the output in cycle t+LAT.
// Assumes LAT >= 1.
module dsms_mul_pipe #(
    parameter int W    = 16,
    parameter int LAT  = 9,
    parameter int TAGW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_v,
    input  logic [W-1:0]    in_a,
    input  logic [W-1:0]    in_b,
    input  logic [TAGW-1:0] in_tag,
    output logic            out_v,
    output logic [2*W-1:0]  out_p,
    output logic [TAGW-1:0] out_tag
);

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        logic            v;
        logic [2*W-1:0]  p;
        logic [TAGW-1:0] t;
        if (g == 0) begin : g_head
            // Input stage: form the product and capture the tag
            always_ff @(posedge clk) begin
                if (!rst_n) v <= 1'b0;
                else        v <= in_v;
                p <= {{W{1'b0}}, in_a} * {{W{1'b0}}, in_b};
                t <= in_tag;
            end
        end else begin : g_body
            // Delay stage: pass the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) v <= 1'b0;
                else        v <= g_stage[g-1].v;
                p <= g_stage[g-1].p;
                t <= g_stage[g-1].t;
            end
        end
    end

    assign out_v   = g_stage[LAT-1].v;
    assign out_p   = g_stage[LAT-1].p;
    assign out_tag = g_stage[LAT-1].t;

endmodule

// File: rtl/dsms_sched.sv
// Issue scheduler for two interleaved operand sets.
// Per set it tracks the current step, the words issued and the words returned.
// A step may issue only after all products of the previous step have returned.
// Priority: finish a started burst, then the set not served last, then the same set.
// Assumes launch is raised only while inactive.
module dsms_sched
    import dsms_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic                ret_v,
    input  logic                ret_set,
    output logic                iss_v,
    output tag_t                iss_tag,
    output logic                active,
    output logic [NUM_SETS-1:0] fin
);

    phase_e     ph_q      [NUM_SETS];
    logic [2:0] iss_cnt_q [NUM_SETS];
    logic [2:0] ret_cnt_q [NUM_SETS];
    logic       last_q;

    logic [NUM_SETS-1:0] ready, ret_hit, ret_last;
    logic                mid, sel;
    logic [2:0]          cnt;

    // Per-set readiness and completion of returns
    always_comb begin
        active = 1'b0;
        for (int s = 0; s < NUM_SETS; s++) begin
            ready[s]    = (ph_q[s] != PH_DONE) && (iss_cnt_q[s] < words_in_phase(ph_q[s]));
            ret_hit[s]  = ret_v && (ret_set == 1'(s));
            ret_last[s] = ret_hit[s] && ((ret_cnt_q[s] + 3'd1) == words_in_phase(ph_q[s]));
            fin[s]      = ret_last[s] && (ph_q[s] == PH_FOLD);
            active      = active | (ph_q[s] != PH_DONE);
        end
    end

    // Pick the set to issue and build its tag
    always_comb begin
        mid   = ready[last_q] && (iss_cnt_q[last_q] != 3'd0);
        sel   = mid ? last_q : (ready[~last_q] ? ~last_q : last_q);
        iss_v = ready[sel];
        cnt   = iss_cnt_q[sel];
        iss_tag.set   = sel;
        iss_tag.phase = ph_q[sel];
        if (ph_q[sel] == PH_FOLD) begin
            iss_tag.wi = {1'b0, cnt[0]};
            iss_tag.wj = 1'b0;
        end else begin
            iss_tag.wi = cnt[2:1];
            iss_tag.wj = cnt[0];
        end
    end

    // Advance the counters and steps; a launch arms both sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b1;
            for (int s = 0; s < NUM_SETS; s++) begin
                ph_q[s]      <= PH_DONE;
                iss_cnt_q[s] <= 3'd0;
                ret_cnt_q[s] <= 3'd0;
            end
        end else if (launch) begin
            last_q <= 1'b1;
            for (int s = 0; s < NUM_SETS; s++) begin
                ph_q[s]      <= PH_PROD;
                iss_cnt_q[s] <= 3'd0;
                ret_cnt_q[s] <= 3'd0;
            end
        end else begin
            if (iss_v) last_q <= sel;
            for (int s = 0; s < NUM_SETS; s++) begin
                if (ret_last[s]) begin
                    ph_q[s]      <= phase_e'(ph_q[s] + 2'd1);
                    iss_cnt_q[s] <= 3'd0;
                    ret_cnt_q[s] <= 3'd0;
                end else begin
                    if (ret_hit[s]) ret_cnt_q[s] <= ret_cnt_q[s] + 3'd1;
                    if (iss_v && (sel == 1'(s))) iss_cnt_q[s] <= iss_cnt_q[s] + 3'd1;
                end
            end
        end
    end

endmodule

// File: rtl/dual_set_mul_sequencer.sv
// Top: schedules the three multiply steps of two operand sets onto one
// LAT-stage N x N multiplier and accumulates the word products per set.
// Assumes N <= ALPHA <= 4N and KSH + 2N <= 5N.
// The constants must be valid in the cycle start is accepted.
module dual_set_mul_sequencer
    import dsms_pkg::*;
#(
    parameter int N     = 16,
    parameter int ALPHA = 24,
    parameter int KSH   = 40,
    parameter int LAT   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    input  logic [2*N-1:0]   op_a0,
    input  logic [2*N-1:0]   op_b0,
    input  logic [2*N-1:0]   op_a1,
    input  logic [2*N-1:0]   op_b1,
    input  logic [2*N-1:0]   barrett_x,
    input  logic [N-1:0]     mod_m,
    output logic             done,
    output logic             done_set,
    output logic [ALPHA-1:0] res_rem,
    output logic [3*N-1:0]   res_quo,
    output logic [2*N-1:0]   res_bq,
    output logic [3*N-1:0]   res_bqm
);

    localparam int W1   = 4 * N;
    localparam int W2   = 5 * N;
    localparam int W3   = 3 * N;
    localparam int TAGW = $bits(tag_t);

    logic [2*N-1:0] opa_q [NUM_SETS];
    logic [2*N-1:0] opb_q [NUM_SETS];
    logic [2*N-1:0] cst_x_q;
    logic [N-1:0]   cst_m_q;
    logic [W1-1:0]  acc1_q [NUM_SETS];
    logic [W2-1:0]  acc2_q [NUM_SETS];
    logic [W3-1:0]  acc3_q [NUM_SETS];

    logic                launch, iss_v, active, ret_v;
    logic [NUM_SETS-1:0] fin;
    tag_t                iss_tag, ret_tag;
    logic [TAGW-1:0]     ret_tag_raw;
    logic [N-1:0]        mul_a, mul_b;
    logic [2*N-1:0]      ret_p;
    logic [W2-1:0]       ret_ext;
    logic                done_q, done_set_q;
    int                  wi_i, wj_i;

    // Upper split of the first product
    function automatic logic [W3-1:0] quo_of(logic [W1-1:0] v);
        logic [W1-1:0] t;
        t = v >> ALPHA;
        return t[W3-1:0];
    endfunction

    // Quotient slice of the second product
    function automatic logic [2*N-1:0] bq_of(logic [W2-1:0] v);
        logic [W2-1:0] t;
        t = v >> KSH;
        return t[2*N-1:0];
    endfunction

    assign launch = start && !active;
    assign busy   = active;

    dsms_sched u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .ret_v   (ret_v),
        .ret_set (ret_tag.set),
        .iss_v   (iss_v),
        .iss_tag (iss_tag),
        .active  (active),
        .fin     (fin)
    );

    // Select the word pair for the issuing set and step
    always_comb begin
        wi_i  = int'(iss_tag.wi);
        wj_i  = int'(iss_tag.wj);
        mul_a = '0;
        mul_b = '0;
        case (iss_tag.phase)
            PH_PROD: begin
                mul_a = opa_q[iss_tag.set][wi_i*N +: N];
                mul_b = opb_q[iss_tag.set][wj_i*N +: N];
            end
            PH_BARRETT: begin
                mul_a = quo_of(acc1_q[iss_tag.set])[wi_i*N +: N];
                mul_b = cst_x_q[wj_i*N +: N];
            end
            PH_FOLD: begin
                mul_a = bq_of(acc2_q[iss_tag.set])[wi_i*N +: N];
                mul_b = cst_m_q;
            end
            default: ;
        endcase
    end

    dsms_mul_pipe #(.W(N), .LAT(LAT), .TAGW(TAGW)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (iss_v),
        .in_a    (mul_a),
        .in_b    (mul_b),
        .in_tag  (iss_tag),
        .out_v   (ret_v),
        .out_p   (ret_p),
        .out_tag (ret_tag_raw)
    );

    assign ret_tag = tag_t'(ret_tag_raw);
    assign ret_ext = W2'(ret_p) << ((int'(ret_tag.wi) + int'(ret_tag.wj)) * N);

    // Capture operands and constants when a batch is launched
    always_ff @(posedge clk) begin
        if (launch) begin
            opa_q[0] <= op_a0;
            opb_q[0] <= op_b0;
            opa_q[1] <= op_a1;
            opb_q[1] <= op_b1;
            cst_x_q  <= barrett_x;
            cst_m_q  <= mod_m;
        end
    end

    // Clear on launch; add each returning product into its set and step
    always_ff @(posedge clk) begin
        for (int s = 0; s < NUM_SETS; s++) begin
            if (!rst_n || launch) begin
                acc1_q[s] <= '0;
                acc2_q[s] <= '0;
                acc3_q[s] <= '0;
            end else if (ret_v && (ret_tag.set == 1'(s))) begin
                case (ret_tag.phase)
                    PH_PROD:    acc1_q[s] <= acc1_q[s] + ret_ext[W1-1:0];
                    PH_BARRETT: acc2_q[s] <= acc2_q[s] + ret_ext;
                    PH_FOLD:    acc3_q[s] <= acc3_q[s] + ret_ext[W3-1:0];
                    default:    ;
                endcase
            end
        end
    end

    // Register the done strobe and the index of the finished set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q     <= 1'b0;
            done_set_q <= 1'b0;
        end else begin
            done_q <= |fin;
            if (|fin) done_set_q <= fin[1];
        end
    end

    assign done     = done_q;
    assign done_set = done_set_q;
    assign res_rem  = acc1_q[done_set_q][ALPHA-1:0];
    assign res_quo  = quo_of(acc1_q[done_set_q]);
    assign res_bq   = bq_of(acc2_q[done_set_q]);
    assign res_bqm  = acc3_q[done_set_q];

endmodule

// File: rtl/dsms_chk.sv
// Protocol checker for the sequencer, attached to the top module by bind.
// Observes the handshake, the strobes, the issue port and the captured constants.
module dsms_chk #(
    parameter int N = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic           done_set,
    input logic           iss_v,
    input logic [2*N-1:0] cst_x,
    input logic [N-1:0]   cst_m
);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R3

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (start && busy) |=> ($stable(cst_x) && $stable(cst_m))); // R2

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5

    AST_LAST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (done && done_set) |-> !busy); // R3

    AST_NO_ISSUE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !iss_v); // R4

endmodule

bind dual_set_mul_sequencer dsms_chk #(.N(N)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .done_set (done_set),
    .iss_v    (iss_v),
    .cst_x    (cst_x_q),
    .cst_m    (cst_m_q)
);

// File: tb/dual_set_mul_sequencer_tb.sv
// Self-checking bench: sweeps operand patterns over a small configuration
// and checks results and strobe timing cycle by cycle.
module dual_set_mul_sequencer_tb_top;

    localparam int N     = 8;
    localparam int ALPHA = 12;
    localparam int KSH   = 20;
    localparam int LAT   = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2*N-1:0]   op_a0 = '0, op_b0 = '0, op_a1 = '0, op_b1 = '0, barrett_x = '0;
    logic [N-1:0]     mod_m = '0;
    logic             busy, done, done_set;
    logic [ALPHA-1:0] res_rem;
    logic [3*N-1:0]   res_quo, res_bqm;
    logic [2*N-1:0]   res_bq;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #2 clk = ~clk;

    dual_set_mul_sequencer #(.N(N), .ALPHA(ALPHA), .KSH(KSH), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
        .op_a0(op_a0), .op_b0(op_b0), .op_a1(op_a1), .op_b1(op_b1),
        .barrett_x(barrett_x), .mod_m(mod_m),
        .done(done), .done_set(done_set),
        .res_rem(res_rem), .res_quo(res_quo), .res_bq(res_bq), .res_bqm(res_bqm)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] v);
        logic [31:0] t;
        t = v ^ (v << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // Compare the result ports with values computed from the operands
    task automatic check_results(input string tagname, input longint unsigned a, input longint unsigned b,
                                 input longint unsigned x, input longint unsigned m);
        longint unsigned p, quo, bq;
        p   = a * b;
        quo = p >> ALPHA;
        bq  = ((quo * x) >> KSH) & ((64'd1 << (2*N)) - 1);
        check({"R6 remainder ", tagname}, res_rem, p & ((64'd1 << ALPHA) - 1));
        check({"R7 quotient ", tagname}, res_quo, quo);
        check({"R8 barrett slice ", tagname}, res_bq, bq);
        check({"R9 fold product ", tagname}, res_bqm, bq * m);
    endtask

    // One batch; called at a falling edge while idle
    task automatic run_batch(input longint unsigned a0, input longint unsigned b0,
                             input longint unsigned a1, input longint unsigned b1,
                             input longint unsigned x, input longint unsigned m,
                             input bit poke, input bit chained);
        check(chained ? "R10 idle at back-to-back start" : "R3 idle before start", busy, 0);
        op_a0 = a0[2*N-1:0]; op_b0 = b0[2*N-1:0];
        op_a1 = a1[2*N-1:0]; op_b1 = b1[2*N-1:0];
        barrett_x = x[2*N-1:0]; mod_m = m[N-1:0];
        start = 1'b1;
        for (int k = 1; k <= 46; k++) begin
            @(negedge clk);
            if (k == 1) start = 1'b0;
            if (poke && k == 10) begin
                start = 1'b1;
                op_a0 = ~op_a0; op_b0 = ~op_b0; op_a1 = ~op_a1; op_b1 = ~op_b1;
                barrett_x = ~barrett_x; mod_m = ~mod_m;
            end
            if (poke && k == 11) start = 1'b0;
            if (k == 1 && chained) check("R10 busy after back-to-back start", busy, 1);
            else check("R3 busy window", busy, (k < 46) ? 1 : 0);
            check((k < 43) ? "R4 done strobe timing" : "R5 done strobe timing", done,
                  (k == 40 || k == 46) ? 1 : 0);
            if (k == 40) begin
                check("R4 done_set for set 0", done_set, 0);
                check_results(poke ? "set0 R2 poked" : "set0", a0, b0, x, m);
            end
            if (k == 46) begin
                check("R5 done_set for set 1", done_set, 1);
                check_results(poke ? "set1 R2 poked" : "set1", a1, b1, x, m);
            end
        end
    endtask

    initial begin
        longint unsigned ra0, rb0, ra1, rb1, rx, rm;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
        run_batch(0, 0, 0, 0, 0, 0, 1'b0, 1'b0);
        run_batch(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 8'hFF, 1'b1, 1'b1);
        run_batch(1, 16'hFFFF, 16'hFFFF, 1, 1, 1, 1'b0, 1'b1);
        run_batch(16'h8000, 16'h0001, 16'h00FF, 16'hFF00, 16'h8001, 8'h80, 1'b1, 1'b1);
        for (int i = 0; i < 30; i++) begin
            seed = next_rand(seed); ra0 = 64'(seed[15:0]); rb0 = 64'(seed[31:16]);
            seed = next_rand(seed); ra1 = 64'(seed[15:0]); rb1 = 64'(seed[31:16]);
            seed = next_rand(seed); rx  = 64'(seed[15:0]); rm  = 64'(seed[23:16]);
            run_batch(ra0, rb0, ra1, rb1, rx, rm, i[0], 1'b1);
        end
        repeat (3) @(negedge clk);
        check("R3 idle after last batch", busy, 0);
        check("R5 no strobe when idle", done, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule